// File: doc/BRIEF.md
# Static Branch Predictor with Jump Folding

This block sits beside the pre-decode stage of a pipelined processor. For every branch that pre-decode presents, it works out the branch direction by comparing the branch target with the branch fetch address. It then gives a taken or not-taken guess from fixed rules, with no history. It also says whether the jump may be folded, which means it runs in parallel with the instruction before it and costs no cycle of its own. Both answers come back combinationally, in the same cycle.

The branch travels down the pipeline carrying its prediction and its fold flag. When it resolves in execute, the block compares the real outcome with the guess. If they differ, it drives a flush pulse lasting one cycle, gives fetch the correct restart address, and reports the refill penalty that is charged to the instruction after the branch. It also reports the cycles charged to the jump itself: zero when folded, one otherwise.

After a flush, the resolve controller spends a fixed refill window in which anything arriving on the resolve port belongs to the cancelled path and is dropped. The controller has three states:
- `ST_RUN`: accepts resolves.
- `ST_FLUSH`: the cycle in which the flush pulse is high.
- `ST_REFILL`: counts out the rest of the window.

The transitions are:
- `ST_RUN` goes to `ST_FLUSH` on an accepted resolve whose outcome differs from its prediction.
- `ST_FLUSH` goes to `ST_REFILL` unconditionally.
- `ST_REFILL` goes back to `ST_RUN` when its down-counter reaches zero.

Top module: `sbp_unit`

## Requirements
- R1: For a bit-condition branch (`pd_kind` = 2'b00), `predict_taken` is 1 exactly when the branch is backward. `pd_uncond` has no effect on this kind.
- R2: For relative (2'b01), absolute (2'b10) and inter-segment (2'b11) branches, `predict_taken` is 1 when `pd_uncond` is 1 or the branch is backward.
- R3: A branch is backward when `pd_target` is less than or equal to `pd_pc`, compared unsigned over the full 24 bits, so a target equal to the fetch address counts as backward.
- R4: `fold_ok` is 1 only for a valid branch of kind relative, absolute or inter-segment, and only when the previous accepted pre-decode slot (`pd_valid`=1) was not a branch. Both outputs are 0 when `pd_valid` or `pd_is_branch` is 0.
- R5: A flush clears the previous-branch history, so the first branch pre-decoded after the resolve that flushed may fold.
- R6: An accepted resolve whose `ex_taken` differs from `ex_pred_taken` raises `flush` for exactly one cycle, in the cycle after the resolve. In that cycle `redirect_addr` is `ex_target` when the branch was taken and `ex_fallthru` otherwise.
- R7: `penalty` equals MISS_PENALTY (default 5, at most 5) in the flush cycle and is 0 in every other cycle.
- R8: An accepted resolve whose outcome matches its prediction produces no flush and a zero penalty, and `redirect_addr` holds its value.
- R9: In the cycle after each accepted resolve, `jump_cycles` becomes 0 if `ex_folded` was 1 and 1 otherwise, whether or not the branch was mispredicted. It holds between accepted resolves.
- R10: For the MISS_PENALTY cycles after a mispredicted resolve, `ex_valid` is ignored: no flush, no change of `redirect_addr` or `jump_cycles`.
- R11: After reset, `flush`, `penalty`, `redirect_addr` and `jump_cycles` are 0 and no branch history is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_valid | input | 1 | Pre-decode slot holds an instruction |
| pd_is_branch | input | 1 | That instruction is a branch |
| pd_kind | input | 2 | 00 bit-condition, 01 relative, 10 absolute, 11 inter-segment |
| pd_uncond | input | 1 | Branch is unconditional |
| pd_pc | input | 24 | Fetch address of the branch |
| pd_target | input | 24 | Branch target address |
| predict_taken | output | 1 | Static guess for the pre-decoded branch |
| fold_ok | output | 1 | Branch may execute in zero cycles |
| ex_valid | input | 1 | A branch resolves this cycle |
| ex_taken | input | 1 | Real outcome |
| ex_pred_taken | input | 1 | Guess carried with the branch |
| ex_folded | input | 1 | Branch was folded |
| ex_target | input | 24 | Taken address |
| ex_fallthru | input | 24 | Not-taken address |
| flush | output | 1 | Cancel fetched instructions (one cycle) |
| redirect_addr | output | 24 | Fetch restart address |
| penalty | output | 3 | Cycles charged to the instruction after the branch |
| jump_cycles | output | 3 | Cycles charged to the last resolved jump itself |

## Verification
`predict_taken` and `fold_ok` are due in the same cycle as the pre-decode inputs. The bench therefore samples them one time unit after driving those inputs on the falling edge. `flush`, `redirect_addr`, `penalty` and `jump_cycles` come from registers and are due one clock after the resolve edge, so the bench compares them at the following falling edge, before it drives the next stimulus. A behavioural model in the bench counts the ignore window down with an integer and tracks the previous-branch history. It is compared with every output on every clock, across directed cases and a long pseudo-random stream.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [1:0] {
        BK_BIT = 2'b00,
        BK_REL = 2'b01,
        BK_ABS = 2'b10,
        BK_SEG = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FLUSH,
        ST_REFILL
    } rs_state_e;
endpackage

// File: rtl/sbp_classify.sv
module sbp_classify
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              valid,
    input  logic              is_branch,
    input  br_kind_e          kind,
    input  logic              uncond,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    output logic              backward,
    output logic              predict_taken
);
    always_comb begin
        backward      = (target <= pc);
        predict_taken = 1'b0;
        if (valid && is_branch) begin
            unique case (kind)
                BK_BIT:                 predict_taken = backward;
                BK_REL, BK_ABS, BK_SEG: predict_taken = uncond || backward;
                default:                predict_taken = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sbp_fold.sv
module sbp_fold
    import sbp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pd_valid,
    input  logic     pd_is_branch,
    input  br_kind_e pd_kind,
    input  logic     clr_hist,
    output logic     fold_ok
);
    logic prev_branch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        prev_branch_q <= 1'b0;
        else if (clr_hist) prev_branch_q <= 1'b0;
        else if (pd_valid) prev_branch_q <= pd_is_branch;
    end

    always_comb begin
        fold_ok = 1'b0;
        if (pd_valid && pd_is_branch && !prev_branch_q) begin
            unique case (pd_kind)
                BK_BIT:                 fold_ok = 1'b0;
                BK_REL, BK_ABS, BK_SEG: fold_ok = 1'b1;
                default:                fold_ok = 1'b0;
            endcase
        end
    end

    // R4: a branch accepted without a flush blocks folding in the next cycle
    p_no_fold_after_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid && pd_is_branch && !clr_hist) |=> !fold_ok);
endmodule

// File: rtl/sbp_resolve.sv
module sbp_resolve
    import sbp_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int MISS_PENALTY = 5,
    parameter int PEN_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    input  logic              ex_taken,
    input  logic              ex_pred_taken,
    input  logic              ex_folded,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic [ADDR_W-1:0] ex_fallthru,
    output logic              clr_hist,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [PEN_W-1:0]  penalty,
    output logic [PEN_W-1:0]  jump_cycles
);
    localparam int        REFILL_N   = (MISS_PENALTY > 1) ? MISS_PENALTY - 2 : 0;
    localparam logic      HAS_REFILL = (MISS_PENALTY > 1);
    localparam logic [PEN_W-1:0] PEN_VAL = PEN_W'(MISS_PENALTY);

    rs_state_e        st_q, st_d;
    logic [PEN_W-1:0] cnt_q, cnt_d;
    logic             accept, mispredict;

    assign accept     = ex_valid && (st_q == ST_RUN);
    assign mispredict = accept && (ex_taken != ex_pred_taken);
    assign clr_hist   = mispredict;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (mispredict) st_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                cnt_d = PEN_W'(REFILL_N);
                st_d  = HAS_REFILL ? ST_REFILL : ST_RUN;
            end
            ST_REFILL: begin
                if (cnt_q == '0) st_d = ST_RUN;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush         <= 1'b0;
            penalty       <= '0;
            redirect_addr <= '0;
            jump_cycles   <= '0;
        end else begin
            flush   <= mispredict;
            penalty <= mispredict ? PEN_VAL : '0;
            if (mispredict)
                redirect_addr <= ex_taken ? ex_target : ex_fallthru;
            if (accept)
                jump_cycles <= ex_folded ? '0 : PEN_W'(1);
        end
    end

    p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);
    p_penalty_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (penalty <= PEN_VAL) && ((penalty != '0) == flush));
    p_hit_no_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && st_q == ST_RUN && ex_taken == ex_pred_taken) |=> (!flush && penalty == '0));
    p_jump_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_valid && st_q == ST_RUN) |=> $stable(jump_cycles));
    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |=> (!flush && $stable(redirect_addr)));
endmodule

// File: rtl/sbp_unit.sv
module sbp_unit
    import sbp_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int MISS_PENALTY = 5,
    parameter int PEN_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_valid,
    input  logic              pd_is_branch,
    input  logic [1:0]        pd_kind,
    input  logic              pd_uncond,
    input  logic [ADDR_W-1:0] pd_pc,
    input  logic [ADDR_W-1:0] pd_target,
    output logic              predict_taken,
    output logic              fold_ok,
    input  logic              ex_valid,
    input  logic              ex_taken,
    input  logic              ex_pred_taken,
    input  logic              ex_folded,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic [ADDR_W-1:0] ex_fallthru,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [PEN_W-1:0]  penalty,
    output logic [PEN_W-1:0]  jump_cycles
);
    br_kind_e kind;
    logic     backward;
    logic     clr_hist;

    assign kind = br_kind_e'(pd_kind);

    sbp_classify #(.ADDR_W(ADDR_W)) u_classify (
        .valid         (pd_valid),
        .is_branch     (pd_is_branch),
        .kind          (kind),
        .uncond        (pd_uncond),
        .pc            (pd_pc),
        .target        (pd_target),
        .backward      (backward),
        .predict_taken (predict_taken)
    );

    sbp_fold u_fold (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_valid     (pd_valid),
        .pd_is_branch (pd_is_branch),
        .pd_kind      (kind),
        .clr_hist     (clr_hist),
        .fold_ok      (fold_ok)
    );

    sbp_resolve #(
        .ADDR_W       (ADDR_W),
        .MISS_PENALTY (MISS_PENALTY),
        .PEN_W        (PEN_W)
    ) u_resolve (
        .clk           (clk),
        .rst_n         (rst_n),
        .ex_valid      (ex_valid),
        .ex_taken      (ex_taken),
        .ex_pred_taken (ex_pred_taken),
        .ex_folded     (ex_folded),
        .ex_target     (ex_target),
        .ex_fallthru   (ex_fallthru),
        .clr_hist      (clr_hist),
        .flush         (flush),
        .redirect_addr (redirect_addr),
        .penalty       (penalty),
        .jump_cycles   (jump_cycles)
    );

    // R1: a bit-condition guess never depends on the unconditional flag
    p_bit_follows_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_valid && pd_is_branch && kind == BK_BIT) |-> (predict_taken == backward));
    // R4: folding never appears together with a bit-condition kind
    p_fold_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fold_ok |-> (kind != BK_BIT && pd_valid && pd_is_branch));
endmodule

// File: tb/tb_sbp_unit.sv
module tb_sbp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MISS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_valid = 0, pd_is_branch = 0, pd_uncond = 0;
    logic [1:0]  pd_kind = 0;
    logic [23:0] pd_pc = 0, pd_target = 0;
    logic        ex_valid = 0, ex_taken = 0, ex_pred_taken = 0, ex_folded = 0;
    logic [23:0] ex_target = 0, ex_fallthru = 0;
    logic        predict_taken, fold_ok, flush;
    logic [23:0] redirect_addr;
    logic [2:0]  penalty, jump_cycles;

    int checks = 0;
    int failures = 0;

    // reference model state
    bit          m_prev = 0;
    int          m_busy = 0;
    bit          m_flush = 0;
    logic [23:0] m_redir = 0;
    int          m_pen = 0;
    int          m_jc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbp_unit dut (
        .clk(clk), .rst_n(rst_n),
        .pd_valid(pd_valid), .pd_is_branch(pd_is_branch), .pd_kind(pd_kind),
        .pd_uncond(pd_uncond), .pd_pc(pd_pc), .pd_target(pd_target),
        .predict_taken(predict_taken), .fold_ok(fold_ok),
        .ex_valid(ex_valid), .ex_taken(ex_taken), .ex_pred_taken(ex_pred_taken),
        .ex_folded(ex_folded), .ex_target(ex_target), .ex_fallthru(ex_fallthru),
        .flush(flush), .redirect_addr(redirect_addr), .penalty(penalty),
        .jump_cycles(jump_cycles)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic set_pd(input bit v, input bit b, input int k, input bit u,
                          input int pc, input int tgt);
        pd_valid = v; pd_is_branch = b; pd_kind = 2'(k); pd_uncond = u;
        pd_pc = 24'(pc); pd_target = 24'(tgt);
    endtask

    task automatic set_ex(input bit v, input bit t, input bit p, input bit f,
                          input int tgt, input int fall);
        ex_valid = v; ex_taken = t; ex_pred_taken = p; ex_folded = f;
        ex_target = 24'(tgt); ex_fallthru = 24'(fall);
    endtask

    // called on a falling edge with inputs already driven
    task automatic tick();
        bit back, e_pred, e_fold, acc, mis;
        #1;
        back   = (pd_target <= pd_pc);                                   // R3
        e_pred = 0;
        if (pd_valid && pd_is_branch)
            e_pred = (pd_kind == 2'b00) ? back : (pd_uncond || back);    // R1 R2
        e_fold = pd_valid && pd_is_branch && pd_kind != 2'b00 && !m_prev; // R4
        chk((pd_kind == 2'b00) ? "R1" : "R2", "predict_taken", int'(predict_taken), int'(e_pred));
        chk("R4", "fold_ok", int'(fold_ok), int'(e_fold));
        @(posedge clk);
        acc = ex_valid && (m_busy == 0);
        mis = acc && (ex_taken != ex_pred_taken);
        m_flush = mis;
        m_pen   = mis ? MISS : 0;
        if (mis) m_redir = ex_taken ? ex_target : ex_fallthru;
        if (acc) m_jc = ex_folded ? 0 : 1;
        if (mis) m_busy = MISS;
        else if (m_busy > 0) m_busy--;
        if (mis) m_prev = 0;                                             // R5
        else if (pd_valid) m_prev = pd_is_branch;
        @(negedge clk);
        chk("R6", "flush", int'(flush), int'(m_flush));
        chk("R6", "redirect_addr", int'(redirect_addr), int'(m_redir));
        chk("R7", "penalty", int'(penalty), m_pen);
        chk("R9", "jump_cycles", int'(jump_cycles), m_jc);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        chk("R11", "flush", int'(flush), 0);
        chk("R11", "penalty", int'(penalty), 0);
        chk("R11", "redirect_addr", int'(redirect_addr), 0);
        chk("R11", "jump_cycles", int'(jump_cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: bit-condition forward -> not taken, no fold
        set_pd(1, 1, 0, 0, 'h100, 'h200); tick();
        // R4: non-branch after branch
        set_pd(1, 0, 1, 0, 'h104, 'h000); tick();
        // R1: bit-condition backward with uncond set: flag ignored
        set_pd(1, 1, 0, 1, 'h300, 'h200); tick();
        set_pd(1, 1, 0, 1, 'h300, 'h400); tick();   // R1 uncond, forward -> 0
        set_pd(1, 0, 0, 0, 0, 0); tick();
        // R2 R4: relative conditional forward after non-branch -> folds
        set_pd(1, 1, 1, 0, 'h500, 'h600); tick();
        // R3: equal address is backward; R4 no fold after branch
        set_pd(1, 1, 1, 0, 'h700, 'h700); tick();
        set_pd(1, 0, 0, 0, 0, 0); tick();
        // R2: absolute unconditional forward; inter-segment conditional backward
        set_pd(1, 1, 2, 1, 'h800, 'hFFFFFF); tick();
        set_pd(0, 0, 0, 0, 0, 0); tick();           // R4 invalid slot keeps history
        set_pd(1, 1, 3, 0, 'hFFFFFF, 'h000001); tick();
        // R8: correct prediction, no flush
        set_pd(0, 0, 0, 0, 0, 0);
        set_ex(1, 1, 1, 0, 'h123, 'h456); tick();
        // R6 R9: folded jump mispredicted, with a branch in pre-decode (R5)
        set_pd(1, 1, 1, 0, 'h10, 'h20);
        set_ex(1, 0, 1, 1, 'hABCDEF, 'h123456); tick();
        // R5: history cleared -> next branch folds; R10: resolves ignored
        set_pd(1, 1, 1, 0, 'h30, 'h40);
        set_ex(1, 1, 0, 0, 'h111111, 'h222222);
        for (int i = 0; i < MISS; i++) tick();
        // R10 window over: this resolve is accepted
        set_pd(0, 0, 0, 0, 0, 0);
        set_ex(1, 1, 0, 0, 'h333333, 'h444444); tick();
        set_ex(0, 0, 0, 0, 0, 0); tick();

        // mixed stream
        for (int i = 0; i < 600; i++) begin
            set_pd($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3),
                   $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 255));
            set_ex($urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(0, 1), $urandom, $urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule